// File: doc/BRIEF.md
# Radix-4 Booth Iterative Signed Multiplier

This block multiplies two two's-complement operands of equal width over several clock cycles. A one-cycle `start_i` pulse, given while the unit is idle, captures the multiplicand and the multiplier. The unit then retires two multiplier bits per cycle. On each step it looks at three neighbouring multiplier bits and recodes them into one digit from the set {0, +M, +2M, -M, -2M}. It adds the sign-extended multiplicand, scaled by that digit, to a running high half. The whole high/low product pair then moves right by two positions.

Subtraction uses the inverted addend plus a carry-in of one, applied in the same adder pass. Doubling is a one-position left shift. A zero sits below the multiplier's least significant bit as the first lower neighbour. After WIDTH/2 steps the full 2·WIDTH-bit signed product is stored in a registered output. `done_o` marks this with a one-cycle pulse, and the product keeps its value until the next operation completes.

Top module: `booth_r4_mul`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy_o` and `done_o` are 0 and `product_o` is 0.
- R2: A `start_i` high at a clock edge with `busy_o` low captures `mcand_i` and `mplier_i`, and `busy_o` reads 1 after that edge.
- R3: `done_o` rises and `busy_o` falls at the WIDTH/2-th clock edge after the capture edge, so each operation takes exactly WIDTH/2 step cycles.
- R4: `done_o` is high for exactly one cycle per operation.
- R5: `start_i` and operand changes while `busy_o` is high have no effect on the running operation or its result.
- R6: When `done_o` is high, `product_o` equals the signed product of the captured operands, as a 2·WIDTH-bit two's-complement value.
- R7: Each window (upper, middle, lower multiplier bit) is recoded as follows: 000 and 111 give 0, 001 and 010 give +M, 011 gives +2M, 100 gives -2M, 101 and 110 give -M. Multipliers built from repeated bit pairs, which produce every window value, give correct products.
- R8: With WIDTH=4, 1010 × 0110 gives 8'b1101_1100 (-36) and 1010 × 1110 gives 8'b0000_1100 (+12).
- R9: The most negative value times itself gives +2^(2·WIDTH-2), for WIDTH=32 and for WIDTH=4 (8'h40).
- R10: `product_o` changes only at an edge where `done_o` becomes 1, and otherwise holds its last value.
- R11: The first step treats the bit below the multiplier LSB as 0, so a multiplier of +1 returns M and -1 returns -M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation when idle |
| mcand_i | input | WIDTH | Signed multiplicand |
| mplier_i | input | WIDTH | Signed multiplier |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 2*WIDTH | Registered signed product |

## Verification
The hardest behaviour to provoke is the -2M digit taken with the most negative multiplicand in the top window. This is the only place where the doubled addend needs both guard bits of the high half. The stimulus reaches it with most-negative-by-most-negative operands at both widths and with repeated bit-pair multipliers such as 0x66666666 and 0xAAAAAAAA. A start pulse with different operands is also injected partway through an operation, to confirm that it leaves the running result untouched.

// File: rtl/booth_r4_pkg.sv
package booth_r4_pkg;
  typedef enum logic [2:0] {
    DIG_ZERO = 3'd0,
    DIG_P1   = 3'd1,
    DIG_P2   = 3'd2,
    DIG_N1   = 3'd3,
    DIG_N2   = 3'd4
  } booth_dig_e;

  function automatic logic dig_is_neg(booth_dig_e d);
    return (d == DIG_N1) || (d == DIG_N2);
  endfunction

  function automatic logic dig_is_dbl(booth_dig_e d);
    return (d == DIG_P2) || (d == DIG_N2);
  endfunction
endpackage

// File: rtl/booth_r4_recode.sv
module booth_r4_recode
  import booth_r4_pkg::*;
(
  input  logic [2:0]  win_i,
  output booth_dig_e  dig_o
);
  always_comb begin
    unique case (win_i)
      3'b000:  dig_o = DIG_ZERO;
      3'b001:  dig_o = DIG_P1;
      3'b010:  dig_o = DIG_P1;
      3'b011:  dig_o = DIG_P2;
      3'b100:  dig_o = DIG_N2;
      3'b101:  dig_o = DIG_N1;
      3'b110:  dig_o = DIG_N1;
      default: dig_o = DIG_ZERO;
    endcase
  end
endmodule

// File: rtl/booth_r4_addend.sv
module booth_r4_addend
  import booth_r4_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AW = WIDTH + 2
) (
  input  logic [WIDTH-1:0] mcand_i,
  input  booth_dig_e       dig_i,
  output logic [AW-1:0]    addend_o,
  output logic             cin_o
);
  logic [AW-1:0] ext_single;
  logic [AW-1:0] ext_double;
  logic [AW-1:0] mag;
  logic          neg;

  assign ext_single = {{2{mcand_i[WIDTH-1]}}, mcand_i};
  assign ext_double = {mcand_i[WIDTH-1], mcand_i, 1'b0};
  assign neg        = dig_is_neg(dig_i);

  always_comb begin
    if (dig_i == DIG_ZERO)    mag = '0;
    else if (dig_is_dbl(dig_i)) mag = ext_double;
    else                        mag = ext_single;
  end

  assign addend_o = neg ? ~mag : mag;
  assign cin_o    = neg;
endmodule

// File: rtl/booth_r4_step.sv
module booth_r4_step #(
  parameter int WIDTH = 32,
  localparam int AW = WIDTH + 2
) (
  input  logic [AW-1:0]    hi_i,
  input  logic [WIDTH-1:0] lo_i,
  input  logic [AW-1:0]    addend_i,
  input  logic             cin_i,
  output logic [AW-1:0]    hi_o,
  output logic [WIDTH-1:0] lo_o,
  output logic             prev_o
);
  logic [AW-1:0] sum;

  assign sum    = hi_i + addend_i + AW'(cin_i);
  assign lo_o   = {sum[1:0], lo_i[WIDTH-1:2]};
  assign hi_o   = {{2{sum[AW-1]}}, sum[AW-1:2]};
  assign prev_o = lo_i[1];
endmodule

// File: rtl/booth_r4_ctrl.sv
module booth_r4_ctrl #(
  parameter int STEPS = 16,
  localparam int CNT_W = $clog2(STEPS) + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEPS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign load_o = start_i && !busy_o;
  assign step_o = busy_o;
  assign last_o = busy_o && (cnt_q == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_o <= 1'b0;
      if (load_o) begin
        busy_o <= 1'b1;
        cnt_q  <= '0;
      end else if (last_o) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
        cnt_q  <= '0;
      end else if (step_o) begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/booth_r4_mul.sv
module booth_r4_mul
  import booth_r4_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  localparam int STEPS = WIDTH / 2;
  localparam int AW    = WIDTH + 2;

  logic [AW-1:0]    hi_q, hi_n;
  logic [WIDTH-1:0] lo_q, lo_n;
  logic             prev_q, prev_n;
  logic [WIDTH-1:0] mcand_q;
  logic [AW-1:0]    addend;
  logic             cin;
  booth_dig_e       dig;
  logic             load, step, last;

  generate
    if (WIDTH % 2 != 0 || WIDTH < 2) begin : g_bad_width
      initial $error("booth_r4_mul: WIDTH must be even and at least 2");
    end
  endgenerate

  booth_r4_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .last_o (last),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  booth_r4_recode u_recode (
    .win_i({lo_q[1:0], prev_q}),
    .dig_o(dig)
  );

  booth_r4_addend #(.WIDTH(WIDTH)) u_addend (
    .mcand_i (mcand_q),
    .dig_i   (dig),
    .addend_o(addend),
    .cin_o   (cin)
  );

  booth_r4_step #(.WIDTH(WIDTH)) u_step (
    .hi_i    (hi_q),
    .lo_i    (lo_q),
    .addend_i(addend),
    .cin_i   (cin),
    .hi_o    (hi_n),
    .lo_o    (lo_n),
    .prev_o  (prev_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q      <= '0;
      lo_q      <= '0;
      prev_q    <= 1'b0;
      mcand_q   <= '0;
      product_o <= '0;
    end else if (load) begin
      hi_q    <= '0;
      lo_q    <= mplier_i;
      prev_q  <= 1'b0;
      mcand_q <= mcand_i;
    end else if (step) begin
      hi_q   <= hi_n;
      lo_q   <= lo_n;
      prev_q <= prev_n;
      if (last) product_o <= {hi_n[WIDTH-1:0], lo_n};
    end
  end
endmodule

// File: rtl/booth_r4_mul_chk.sv
module booth_r4_mul_chk #(
  parameter int WIDTH = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [2*WIDTH-1:0] product_o
);
  localparam int STEPS = WIDTH / 2;
  localparam int CW    = $clog2(STEPS) + 2;

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst)         run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + 1'b1;
    else             run_cnt <= '0;
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    $fell(rst) |-> (!busy_o && !done_o && product_o == '0)); // R1

  AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o); // R2

  AST_STEP_COUNT: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (run_cnt == CW'(STEPS) && done_o)); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R4

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R3

  AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(product_o)); // R10
endmodule

bind booth_r4_mul booth_r4_mul_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .product_o(product_o)
);

// File: tb/booth_r4_mul_tb.sv
module booth_r4_mul_tb;
  localparam int W     = 32;
  localparam int STEPS = W / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  mcand = '0, mplier = '0;
  logic          busy, done;
  logic [2*W-1:0] product;

  logic          s_start = 1'b0;
  logic [3:0]    s_mcand = '0, s_mplier = '0;
  logic          s_busy, s_done;
  logic [7:0]    s_product;

  int checks = 0;
  int errors = 0;

  logic [2*W-1:0] exp_q[$];
  string          tag_q[$];

  always #5 clk = ~clk;

  booth_r4_mul #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .mcand_i(mcand), .mplier_i(mplier),
    .busy_o(busy), .done_o(done), .product_o(product)
  );

  booth_r4_mul #(.WIDTH(4)) u_dut4 (
    .clk(clk), .rst(rst), .start_i(s_start), .mcand_i(s_mcand), .mplier_i(s_mplier),
    .busy_o(s_busy), .done_o(s_done), .product_o(s_product)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [2*W-1:0] sa, sb;
    sa = $signed({{W{a[W-1]}}, a});
    sb = $signed({{W{b[W-1]}}, b});
    return sa * sb;
  endfunction

  // Monitor: pops the scoreboard whenever a result appears.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected done", 64'(product), 64'd0);
        end else begin
          logic [2*W-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(product == e, t, 64'(product), 64'(e));
        end
      end
    end
  end

  // Driver: queues the expectation, starts, and checks timing at the ports.
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input string tag,
                        input bit poke_busy);
    exp_q.push_back(ref_mul(a, b));
    tag_q.push_back(tag);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
    for (int i = 1; i < STEPS; i++) begin
      if (poke_busy && i == 2) begin
        mcand = ~a; mplier = b ^ 32'h1234_5678; start = 1'b1;   // R5 ignored
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      if (i == STEPS - 1) chk(done == 1'b0 && busy == 1'b1, "R3 no early done", 64'(done), 64'd0);
    end
    start = 1'b0;
    @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R3 done at step count", 64'({busy, done}), 64'b01);
    @(negedge clk);
    chk(done == 1'b0, "R4 single-cycle done", 64'(done), 64'd0);
  endtask

  task automatic run4(input logic [3:0] a, input logic [3:0] b, input logic [7:0] exp, input string tag);
    s_mcand = a; s_mplier = b; s_start = 1'b1;
    @(negedge clk);
    s_start = 1'b0;
    repeat (2) @(negedge clk);
    chk(s_done == 1'b1 && s_product == exp, tag, 64'(s_product), 64'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && product == '0, "R1 reset state", 64'(product), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && product == '0 && !s_busy && s_product == '0, "R1 after reset",
        64'(product), 64'd0);

    // R8 worked 4-bit cases, R9 most negative at 4 bits
    run4(4'b1010, 4'b0110, 8'b1101_1100, "R8 -6 x 6");
    run4(4'b1010, 4'b1110, 8'b0000_1100, "R8 -6 x -2");
    run4(4'b1000, 4'b1000, 8'h40,        "R9 4-bit most negative");

    // R11 implied zero below LSB
    run_op(32'hDEAD_BEEF, 32'd1,         "R11 times +1", 1'b0);
    run_op(32'h1357_9BDF, 32'hFFFF_FFFF, "R11 times -1", 1'b0);

    // R9 most negative squared
    run_op(32'h8000_0000, 32'h8000_0000, "R9 most negative", 1'b0);
    run_op(32'h8000_0000, 32'h7FFF_FFFF, "R9 min x max", 1'b0);

    // R7 every recoding window value
    run_op(32'h8000_0000, 32'h6666_6666, "R7 windows 100/011", 1'b0);
    run_op(32'h7FFF_FFFF, 32'hAAAA_AAAA, "R7 windows 100/101", 1'b0);
    run_op(32'hC0FF_EE01, 32'h3333_3333, "R7 windows 110/001", 1'b0);
    run_op(32'h0000_0007, 32'h5555_5555, "R7 window 010", 1'b0);
    run_op(32'hFFFF_FFF9, 32'hCCCC_CCCC, "R7 windows 000/110/001", 1'b0);
    run_op(32'h1234_5678, 32'h0000_0000, "R7 window 000 zero", 1'b0);

    // R5 start during busy ignored
    run_op(32'h0BAD_F00D, 32'hF00D_0BAD, "R5 start while busy", 1'b1);

    // R10 product holds while idle inputs change
    begin
      logic [2*W-1:0] held;
      held = product;
      for (int i = 0; i < 5; i++) begin
        mcand = $urandom; mplier = $urandom;
        @(negedge clk);
      end
      chk(product == held, "R10 product holds", 64'(product), 64'(held));
    end

    // R6 random signed operands
    for (int n = 0; n < 200; n++) begin
      run_op($urandom, $urandom, "R6 random", 1'b0);
    end

    @(negedge clk);
    chk(exp_q.size() == 0, "R6 all results seen", 64'(exp_q.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule